// File: doc/BRIEF.md
# Condition Code Flag Unit

This block keeps the 8-bit condition-code register of a small accumulator-based CPU core and works out its next value on every clock. The core's execute stage gives it an operation class together with the two ALU operands, the ALU result and three side signals from the adder and shifter: carry/borrow out, carry out of bit 3, and an overflow indication. The unit then applies the update rule of that class. Five status flags follow the result. The STOP-disable bit and the two interrupt masks are written only through the direct-load path or the interrupt-entry strobe.

The direct-load path handles transfers from an accumulator and the restore from the stack on return from interrupt. The core pulses the interrupt-entry strobe once the registers have been stacked and before it fetches the vector. A combinational pair of outputs tells the core whether a pending STOP request must run or be treated as a no-op.

Bit layout of the register, bit 7 down to bit 0: S (stop disable), X (non-maskable line mask), H (half carry), I (interrupt mask), N, Z, V, C.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0xD0: S, X and I are set and H, N, Z, V, C are clear.
- R2: Add class (op 1): H takes the half-carry input and C takes the carry input. N and Z come from the result at the selected width. V is set when both operands have the same sign and the result's sign differs from it.
- R3: H changes only under the add class or a direct load. Every other class leaves it unchanged.
- R4: Subtract/compare class (op 2): N and Z come from the result and C takes the borrow from the carry input. V is set when the operand signs differ and the result's sign differs from the first operand's. H is unchanged.
- R5: With the width input low, N, V and Z use only bits 7..0 of operands and result, and bits above are ignored. With it high, they use bits 15..0.
- R6: Index class (op 6): Z is set when all 16 result bits are zero, whatever the width input. All other bits are unchanged.
- R7: Logic/load class (op 3): N and Z follow the result and V is cleared. C and H are unchanged.
- R8: Shift/rotate class (op 4): C takes the bit shifted out (carry input). N and Z follow the result, and V becomes the new N exclusive-or the new C.
- R9: Increment/decrement class (op 5): N and Z follow the result, V takes the overflow input, and C is unchanged.
- R10: A direct load writes all eight bits from the load value, except that X can only be cleared this way and never set.
- R11: The interrupt-entry strobe sets I and leaves every other bit unchanged. In that cycle it overrides both a direct load and the operation class.
- R12: stop_exec_o equals stop_req_i with S clear, and stop_nop_o equals stop_req_i with S set. Both are combinational.
- R13: Class 0 (none) and the reserved class 7 leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation class code |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opa_i | input | 16 | First ALU operand |
| opb_i | input | 16 | Second ALU operand |
| res_i | input | 16 | ALU result (also the implied result of a compare) |
| carry_i | input | 1 | Carry/borrow out, or bit shifted out |
| half_i | input | 1 | Carry out of bit 3 |
| ovf_i | input | 1 | Overflow from increment/decrement |
| load_i | input | 1 | Direct load strobe |
| load_val_i | input | 8 | Direct load value |
| irq_entry_i | input | 1 | Interrupt-entry strobe |
| stop_req_i | input | 1 | STOP instruction reached |
| ccr_o | output | 8 | Condition-code register |
| stop_exec_o | output | 1 | STOP must execute |
| stop_nop_o | output | 1 | STOP acts as no-op |

## Verification
The bench targets several corner cases, each with a distinct symptom if the design gets it wrong:
- An 8-bit add whose carry lands in bit 8 must give Z set. A design that tests Z across the full word would clear it.
- Overflow cases with both sign patterns, for add and for subtract, catch V rules that use the wrong sign comparison.
- An index operation on 0x0100 with the width input low must leave Z clear and the other flags untouched. A narrow zero test, or a general update, would disturb them.
- Loading all ones after X has been cleared must leave X clear.
- An interrupt entry together with a load and an operation must set only I. A design with the wrong priority would let the load or the flags through.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   typedef enum logic [2:0] {
      CC_NONE   = 3'd0,
      CC_ADD    = 3'd1,
      CC_SUB    = 3'd2,
      CC_LOGIC  = 3'd3,
      CC_SHIFT  = 3'd4,
      CC_INCDEC = 3'd5,
      CC_IDX    = 3'd6,
      CC_RSVD   = 3'd7
   } cc_class_e;

   localparam int unsigned B_C = 0;
   localparam int unsigned B_V = 1;
   localparam int unsigned B_Z = 2;
   localparam int unsigned B_N = 3;
   localparam int unsigned B_I = 4;
   localparam int unsigned B_H = 5;
   localparam int unsigned B_X = 6;
   localparam int unsigned B_S = 7;

   localparam logic [7:0] CCR_RESET = 8'hD0;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } stat_t;

endpackage

// File: rtl/ccr_eval.sv
module ccr_eval
   import ccr_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  cc_class_e          op_i,
   input  logic               wide_i,
   input  logic [WORD_W-1:0]  opa_i,
   input  logic [WORD_W-1:0]  opb_i,
   input  logic [WORD_W-1:0]  res_i,
   input  logic               carry_i,
   input  logic               half_i,
   input  logic               ovf_i,
   input  stat_t              cur_i,
   output stat_t              nxt_o
);
   localparam int unsigned WMSB = WORD_W - 1;
   localparam int unsigned BMSB = BYTE_W - 1;

   logic a_s, b_s, r_s;
   logic z_sel, z_full;
   logic v_add, v_sub, n_shift;
   logic unused_opnd;

   initial begin
      assert (BYTE_W >= 1 && WORD_W >= BYTE_W)
         else $error("ccr_eval: WORD_W must be at least BYTE_W");
   end

   assign z_full = ~|res_i;

   // width choice: one width only, or byte/word selected per operation (R5)
   generate
      if (WORD_W == BYTE_W) begin : g_single
         assign a_s   = opa_i[WMSB];
         assign b_s   = opb_i[WMSB];
         assign r_s   = res_i[WMSB];
         assign z_sel = z_full;
         logic unused_wide;
         assign unused_wide = wide_i;
      end else begin : g_dual
         assign a_s   = wide_i ? opa_i[WMSB] : opa_i[BMSB];
         assign b_s   = wide_i ? opb_i[WMSB] : opb_i[BMSB];
         assign r_s   = wide_i ? res_i[WMSB] : res_i[BMSB];
         assign z_sel = wide_i ? z_full : ~|res_i[BMSB:0];
      end
   endgenerate

   assign unused_opnd = ^{opa_i, opb_i};

   assign v_add   = (a_s == b_s) && (r_s != a_s);
   assign v_sub   = (a_s != b_s) && (r_s != a_s);
   assign n_shift = r_s;

   always_comb begin
      nxt_o = cur_i;
      unique case (op_i)
         CC_ADD: begin
            nxt_o.h = half_i;
            nxt_o.n = r_s;
            nxt_o.z = z_sel;
            nxt_o.v = v_add;
            nxt_o.c = carry_i;
         end
         CC_SUB: begin
            nxt_o.n = r_s;
            nxt_o.z = z_sel;
            nxt_o.v = v_sub;
            nxt_o.c = carry_i;
         end
         CC_LOGIC: begin
            nxt_o.n = r_s;
            nxt_o.z = z_sel;
            nxt_o.v = 1'b0;
         end
         CC_SHIFT: begin
            nxt_o.n = n_shift;
            nxt_o.z = z_sel;
            nxt_o.c = carry_i;
            nxt_o.v = n_shift ^ carry_i;
         end
         CC_INCDEC: begin
            nxt_o.n = r_s;
            nxt_o.z = z_sel;
            nxt_o.v = ovf_i;
         end
         CC_IDX: begin
            nxt_o.z = z_full;
         end
         default: nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/ccr_mask.sv
module ccr_mask
   import ccr_pkg::*;
#(
   parameter bit X_STICKY = 1'b1
) (
   input  logic cur_s_i,
   input  logic cur_x_i,
   input  logic cur_i_i,
   input  logic load_i,
   input  logic load_s_i,
   input  logic load_x_i,
   input  logic load_m_i,
   input  logic irq_entry_i,
   output logic nxt_s_o,
   output logic nxt_x_o,
   output logic nxt_i_o
);
   logic x_from_load;

   // X may be cleared by a load; the sticky variant never lets a load set it
   generate
      if (X_STICKY) begin : g_sticky
         assign x_from_load = cur_x_i & load_x_i;
      end else begin : g_free
         assign x_from_load = load_x_i;
      end
   endgenerate

   always_comb begin
      nxt_s_o = cur_s_i;
      nxt_x_o = cur_x_i;
      nxt_i_o = cur_i_i;
      if (irq_entry_i) begin
         nxt_i_o = 1'b1;
      end else if (load_i) begin
         nxt_s_o = load_s_i;
         nxt_x_o = x_from_load;
         nxt_i_o = load_m_i;
      end
   end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
   import ccr_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned BYTE_W   = 8,
   parameter bit          X_STICKY = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        op_i,
   input  logic              wide_i,
   input  logic [WORD_W-1:0] opa_i,
   input  logic [WORD_W-1:0] opb_i,
   input  logic [WORD_W-1:0] res_i,
   input  logic              carry_i,
   input  logic              half_i,
   input  logic              ovf_i,
   input  logic              load_i,
   input  logic [7:0]        load_val_i,
   input  logic              irq_entry_i,
   input  logic              stop_req_i,
   output logic [7:0]        ccr_o,
   output logic              stop_exec_o,
   output logic              stop_nop_o
);
   logic [7:0] ccr_q, ccr_d;
   stat_t      stat_cur, stat_eval, stat_nxt;
   logic       s_nxt, x_nxt, i_nxt;
   cc_class_e  op_cls;

   initial begin
      assert (WORD_W <= 64) else $error("ccr_flag_unit: WORD_W out of range");
   end

   assign op_cls   = cc_class_e'(op_i);
   assign stat_cur = '{h: ccr_q[B_H], n: ccr_q[B_N], z: ccr_q[B_Z],
                       v: ccr_q[B_V], c: ccr_q[B_C]};

   ccr_eval #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_eval (
      .op_i    (op_cls),
      .wide_i  (wide_i),
      .opa_i   (opa_i),
      .opb_i   (opb_i),
      .res_i   (res_i),
      .carry_i (carry_i),
      .half_i  (half_i),
      .ovf_i   (ovf_i),
      .cur_i   (stat_cur),
      .nxt_o   (stat_eval)
   );

   ccr_mask #(.X_STICKY(X_STICKY)) i_mask (
      .cur_s_i     (ccr_q[B_S]),
      .cur_x_i     (ccr_q[B_X]),
      .cur_i_i     (ccr_q[B_I]),
      .load_i      (load_i),
      .load_s_i    (load_val_i[B_S]),
      .load_x_i    (load_val_i[B_X]),
      .load_m_i    (load_val_i[B_I]),
      .irq_entry_i (irq_entry_i),
      .nxt_s_o     (s_nxt),
      .nxt_x_o     (x_nxt),
      .nxt_i_o     (i_nxt)
   );

   // priority: interrupt entry, then direct load, then class rule
   always_comb begin
      if (irq_entry_i) begin
         stat_nxt = stat_cur;
      end else if (load_i) begin
         stat_nxt = '{h: load_val_i[B_H], n: load_val_i[B_N], z: load_val_i[B_Z],
                      v: load_val_i[B_V], c: load_val_i[B_C]};
      end else begin
         stat_nxt = stat_eval;
      end
      ccr_d        = '0;
      ccr_d[B_S]   = s_nxt;
      ccr_d[B_X]   = x_nxt;
      ccr_d[B_H]   = stat_nxt.h;
      ccr_d[B_I]   = i_nxt;
      ccr_d[B_N]   = stat_nxt.n;
      ccr_d[B_Z]   = stat_nxt.z;
      ccr_d[B_V]   = stat_nxt.v;
      ccr_d[B_C]   = stat_nxt.c;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ccr_q <= CCR_RESET;
      else         ccr_q <= ccr_d;
   end

   assign ccr_o       = ccr_q;
   assign stop_exec_o = stop_req_i & ~ccr_q[B_S];
   assign stop_nop_o  = stop_req_i &  ccr_q[B_S];

   // R1: the first sampled cycle out of reset shows the reset value
   p_reset_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> ccr_o == 8'hD0);

   // R3: H holds unless an add or a load is applied
   p_h_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i != 3'd1 && !load_i) |=> ccr_o[5] == $past(ccr_o[5]));

   // R6: index class touches only Z
   p_idx_z_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd6 && !load_i && !irq_entry_i)
      |=> ({ccr_o[7:3], ccr_o[1:0]} == $past({ccr_o[7:3], ccr_o[1:0]})));

   // R11: interrupt entry leaves I set and nothing else moves
   p_irq_sets_i_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_entry_i |=> (ccr_o[4] && {ccr_o[7:5], ccr_o[3:0]} == $past({ccr_o[7:5], ccr_o[3:0]})));

   // R12: a STOP request resolves to exactly one outcome, and never runs with S set
   p_stop_one_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_req_i |-> ((stop_exec_o ^ stop_nop_o) && !(ccr_o[7] && stop_exec_o)));

   generate
      if (X_STICKY) begin : g_x_chk
         // R10: once clear, X stays clear until reset
         p_x_no_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ccr_o[6] |=> !ccr_o[6]);
      end
   endgenerate

endmodule

// File: tb/test_ccr_flag_unit.sv
module test_ccr_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = '0;
   logic        wide = 1'b0;
   logic [15:0] opa = '0, opb = '0, res = '0;
   logic        carry = 1'b0, half = 1'b0, ovf = 1'b0;
   logic        load = 1'b0;
   logic [7:0]  load_val = '0;
   logic        irq = 1'b0;
   logic        stop_req = 1'b0;
   logic [7:0]  ccr;
   logic        stop_exec, stop_nop;
   int          checks = 0;
   int          fails = 0;

   always #5 clk = ~clk;

   ccr_flag_unit i_ccr_flag_unit (
      .clk_i(clk), .rst_ni(rst_n), .op_i(op), .wide_i(wide),
      .opa_i(opa), .opb_i(opb), .res_i(res),
      .carry_i(carry), .half_i(half), .ovf_i(ovf),
      .load_i(load), .load_val_i(load_val), .irq_entry_i(irq),
      .stop_req_i(stop_req), .ccr_o(ccr),
      .stop_exec_o(stop_exec), .stop_nop_o(stop_nop)
   );

   // op, wide, opa, opb, res, carry, half, ovf, expected register after the edge
   localparam int NV = 14;
   localparam logic [62:0] VT [NV] = '{
      {3'd1, 1'b0, 16'h0050, 16'h0050, 16'h00A0, 1'b0, 1'b0, 1'b0, 8'hDA}, // add, V from sign
      {3'd1, 1'b0, 16'h008F, 16'h0071, 16'h0100, 1'b1, 1'b1, 1'b0, 8'hF5}, // R5 bit 8 ignored
      {3'd2, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 1'b1, 1'b0, 8'hF2}, // sub overflow, R3 H kept
      {3'd3, 1'b1, 16'h0000, 16'h0000, 16'h8000, 1'b1, 1'b0, 1'b0, 8'hF8}, // logic wide N
      {3'd2, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, 8'hF4}, // compare equal
      {3'd6, 1'b0, 16'h0000, 16'h0000, 16'h0100, 1'b1, 1'b1, 1'b1, 8'hF0}, // index full-width Z
      {3'd4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 8'hF7}, // shift V=N^C
      {3'd5, 1'b0, 16'h007F, 16'h0000, 16'h0080, 1'b0, 1'b0, 1'b1, 8'hFB}, // inc overflow
      {3'd6, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 8'hFF}, // index Z only
      {3'd0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 8'hFF}, // none
      {3'd7, 1'b1, 16'h0000, 16'h0000, 16'h1234, 1'b0, 1'b1, 1'b0, 8'hFF}, // reserved
      {3'd1, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 1'b0, 8'hFA}, // wide add pos overflow
      {3'd1, 1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b0, 1'b0, 8'hD7}, // wide add neg overflow
      {3'd2, 1'b0, 16'h0001, 16'h0002, 16'h00FF, 1'b1, 1'b1, 1'b0, 8'hD9}  // borrow, H kept
   };

   function automatic string tag_of(logic [2:0] c);
      case (c)
         3'd1: return "R2";
         3'd2: return "R4";
         3'd3: return "R7";
         3'd4: return "R8";
         3'd5: return "R9";
         3'd6: return "R6";
         default: return "R13";
      endcase
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      op = 3'd0; load = 1'b0; irq = 1'b0; carry = 1'b0; half = 1'b0; ovf = 1'b0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", ccr, 8'hD0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", ccr, 8'hD0);
      stop_req = 1'b1;
      #1;
      check("R12", {6'd0, stop_exec, stop_nop}, 8'h01);
      stop_req = 1'b0;

      for (int k = 0; k < NV; k++) begin
         {op, wide, opa, opb, res, carry, half, ovf} = VT[k][62:8];
         @(negedge clk);
         check(tag_of(VT[k][62:60]), ccr, VT[k][7:0]);
      end
      idle();

      // R10: clearing X through a load, then trying to set it again
      load = 1'b1; load_val = 8'h00;
      @(negedge clk);
      check("R10", ccr, 8'h00);
      stop_req = 1'b1;
      #1;
      check("R12", {6'd0, stop_exec, stop_nop}, 8'h02);
      load_val = 8'hFF;
      @(negedge clk);
      check("R10", ccr, 8'hBF);
      #1;
      check("R12", {6'd0, stop_exec, stop_nop}, 8'h01);
      stop_req = 1'b0;

      // R11: interrupt entry wins over a load and a logic op in the same cycle
      load_val = 8'h00;
      @(negedge clk);
      check("R10", ccr, 8'h00);
      irq = 1'b1; load_val = 8'hFF; op = 3'd3; wide = 1'b1; res = 16'h8000;
      @(negedge clk);
      check("R11", ccr, 8'h10);
      load = 1'b0; op = 3'd0;
      @(negedge clk);
      check("R11", ccr, 8'h10);
      idle();

      // R1: reset again restores the masks, X included
      rst_n = 1'b0;
      #1;
      check("R1", ccr, 8'hD0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", ccr, 8'hD0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule